// File: doc/BRIEF.md
# Loop Table Fetch Bypass Controller

This block sits in the instruction fetch path of a small microcontroller, between the fetch stage and the program ROM. A few frequently executed loops are copied into a small on-chip loop table. When the fetch address falls inside one of these loops, the instruction comes from the table and the ROM is left idle, which saves ROM access power. Which loops are served is fixed at reset and never detected at runtime. After reset a loader walks a small configuration memory. If that memory's enable flag is set, the loader captures a start and end address for each loop slot and then turns the bypass on.

Once the fetch stream is inside a loop, no address comparison is made. Two exit bits stored with every table word say whether that instruction can leave the loop, and whether it leaves when its jump is taken or when it is not taken. The core reports the jump outcome together with the next fetch address. On that same cycle the block hands the fetch back to the ROM. The ROM and the loop table are both combinational reads, so the instruction returned and the cycle in which it arrives are the same whichever source supplies it.

Top module: `loop_fetch_bypass`

## Requirements
- R1: Configuration word 0 bit 0 is the enable flag. Word 2k+1 is the first address of loop k and word 2k+2 is its last address. The loader reads words 0 to 2*NLOOP, one per clock, starting with cfg_rd_addr = 0 during reset. With the flag set, bypass_on rises on the (2*NLOOP+3)-th rising edge after rst_n is released, which is the 7th edge for the default parameters. This count includes two edges of reset synchronization. Once high, bypass_on stays high until the next reset.
- R2: With the flag clear, bypass_on stays low and every fetch is served by the ROM.
- R3: With the bypass on and no loop currently active, a fetch address outside every valid loop range is served by the ROM: rom_en = 1, from_table = 0, instr_out = rom_data.
- R4: With no loop active, a fetch address A inside loop k (start <= A <= end) is served in the same cycle from table index k*LDEPTH + (A - start). A table word holds the instruction in bits [IW-1:0] and the exit code in bits [IW+1:IW]. On such a fetch rom_en = 0, from_table = 1 and instr_out equals the stored instruction.
- R5: After a table instruction with exit code 00, the next fetch is served from the table at active-loop start offset plus base, whatever jump_taken is.
- R6: After a table instruction with exit code 01, the next fetch goes to the ROM if jump_taken is 1 and stays in the table if it is 0.
- R7: After a table instruction with exit code 10, the next fetch goes to the ROM if jump_taken is 0 and stays in the table if it is 1.
- R8: After a table instruction with exit code 11, the next fetch goes to the ROM whatever jump_taken is. Range matching resumes on the fetch after that.
- R9: A loop slot whose last address is below its first, or which spans more than LDEPTH instructions, never matches, so its addresses go to the ROM. A loop of exactly LDEPTH instructions is valid.
- R10: While fetch_req is low, rom_en and from_table are low and the loop state is held. The next requested fetch continues as if no gap had occurred.
- R11: When the ranges of two valid loops overlap, the loop with the lower slot number serves the overlapping address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_rd_addr | output | clog2(2*NLOOP+1) | Configuration memory word address |
| cfg_rd_data | input | AW | Configuration memory read data (combinational) |
| tbl_wr_en | input | 1 | Loop table write strobe |
| tbl_wr_addr | input | clog2(NLOOP*LDEPTH) | Loop table write index |
| tbl_wr_data | input | IW+2 | Table word: exit code in [IW+1:IW], instruction in [IW-1:0] |
| fetch_req | input | 1 | Core requests an instruction this cycle |
| fetch_addr | input | AW | Fetch address |
| jump_taken | input | 1 | Outcome of the jump in the previously fetched instruction |
| rom_data | input | IW | Program ROM read data (combinational) |
| rom_en | output | 1 | ROM access enable, high only for ROM-served fetches |
| instr_out | output | IW | Instruction returned to the core |
| from_table | output | 1 | Fetch source select: 1 = loop table |
| bypass_on | output | 1 | Bypass enabled after configuration load |

## Verification
The bench goes after each exit code under both jump outcomes. A swapped decode of 01 and 10 would keep serving the table after a taken forward exit and return stale loop words in place of the jump target. It re-enters loops at their first address, in mid-range and in the second slot, which catches a wrong base slot or an offset taken from the wrong start register. It also covers a stall inside a loop, which a design that advances state without a request would fall out of. Further cases are loops at and just beyond the maximum span, overlapping ranges where a reversed priority picks the wrong slot, and a cleared enable flag where a design that ignored it would hand out table words.

// File: rtl/lfb_pkg.sv
`timescale 1ns/1ps
package lfb_pkg;
  // two-bit leave rule stored beside every table instruction
  typedef enum logic [1:0] {
    EXIT_NONE     = 2'b00,
    EXIT_ON_TAKEN = 2'b01,
    EXIT_ON_FALL  = 2'b10,
    EXIT_ALWAYS   = 2'b11
  } exit_code_e;

  typedef enum logic [1:0] {
    LD_FLAG = 2'b00,
    LD_ADDR = 2'b01,
    LD_DONE = 2'b10
  } ld_state_e;
endpackage

// File: rtl/lfb_cfg_loader.sv
`timescale 1ns/1ps
module lfb_cfg_loader
  import lfb_pkg::*;
#(
  parameter int AW     = 16,
  parameter int NLOOP  = 2,
  parameter int LDEPTH = 32,
  parameter int CAW    = $clog2(2*NLOOP+1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output logic [CAW-1:0]             cfg_rd_addr,
  input  logic [AW-1:0]              cfg_rd_data,
  output logic [NLOOP-1:0][AW-1:0]   loop_start,
  output logic [NLOOP-1:0][AW-1:0]   loop_end,
  output logic [NLOOP-1:0]           loop_valid,
  output logic                       bypass_on
);
  localparam logic [CAW-1:0] LAST_WORD = CAW'(2*NLOOP);
  localparam logic [AW-1:0]  SPAN_LIM  = AW'(LDEPTH);

  ld_state_e                 state_q, state_d;
  logic [CAW-1:0]            cnt_q, cnt_d;
  logic [NLOOP-1:0][AW-1:0]  start_q, start_d;
  logic [NLOOP-1:0][AW-1:0]  end_q, end_d;
  logic [NLOOP-1:0]          valid_q, valid_d;
  logic                      byp_q, byp_d;

  always_comb begin
    logic [AW-1:0] span;
    span    = '0;
    state_d = state_q;
    cnt_d   = cnt_q;
    start_d = start_q;
    end_d   = end_q;
    valid_d = valid_q;
    byp_d   = byp_q;
    case (state_q)
      LD_FLAG: begin
        if (cfg_rd_data[0]) begin
          state_d = LD_ADDR;
          cnt_d   = cnt_q + 1'b1;
        end else begin
          state_d = LD_DONE;
        end
      end
      LD_ADDR: begin
        for (int k = 0; k < NLOOP; k++) begin
          if (cnt_q == CAW'(2*k+1)) start_d[k] = cfg_rd_data;
          if (cnt_q == CAW'(2*k+2)) begin
            end_d[k]   = cfg_rd_data;
            span       = cfg_rd_data - start_q[k];
            valid_d[k] = (cfg_rd_data >= start_q[k]) && (span < SPAN_LIM);
          end
        end
        if (cnt_q == LAST_WORD) begin
          state_d = LD_DONE;
          byp_d   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_FLAG;
      cnt_q   <= '0;
      start_q <= '0;
      end_q   <= '0;
      valid_q <= '0;
      byp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
      end_q   <= end_d;
      valid_q <= valid_d;
      byp_q   <= byp_d;
    end
  end

  assign cfg_rd_addr = cnt_q;
  assign loop_start  = start_q;
  assign loop_end    = end_q;
  assign loop_valid  = valid_q;
  assign bypass_on   = byp_q;

  // R1: enable is sticky and the word address never passes the last word
  assert_bypass_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_on |=> bypass_on);
  assert_cfg_addr_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_addr <= LAST_WORD);
endmodule

// File: rtl/lfb_range_match.sv
`timescale 1ns/1ps
module lfb_range_match #(
  parameter int AW     = 16,
  parameter int NLOOP  = 2,
  parameter int LDEPTH = 32,
  parameter int TW     = $clog2(NLOOP*LDEPTH)
) (
  input  logic [AW-1:0]              fetch_addr,
  input  logic [NLOOP-1:0][AW-1:0]   loop_start,
  input  logic [NLOOP-1:0][AW-1:0]   loop_end,
  input  logic [NLOOP-1:0]           loop_valid,
  output logic                       hit,
  output logic [AW-1:0]              hit_start,
  output logic [TW-1:0]              hit_base
);
  logic [NLOOP-1:0] in_rng;

  for (genvar k = 0; k < NLOOP; k++) begin : g_cmp
    assign in_rng[k] = loop_valid[k] &&
                       (fetch_addr >= loop_start[k]) &&
                       (fetch_addr <= loop_end[k]);
  end

  // lowest slot wins on overlap: scan from the top so it is written last
  always_comb begin
    hit       = 1'b0;
    hit_start = '0;
    hit_base  = '0;
    for (int k = NLOOP-1; k >= 0; k--) begin
      if (in_rng[k]) begin
        hit       = 1'b1;
        hit_start = loop_start[k];
        hit_base  = TW'(k*LDEPTH);
      end
    end
  end
endmodule

// File: rtl/lfb_table.sv
`timescale 1ns/1ps
module lfb_table #(
  parameter int WW    = 10,
  parameter int DEPTH = 64,
  parameter int TW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_addr,
  input  logic [WW-1:0] wr_data,
  input  logic [TW-1:0] rd_addr,
  output logic [WW-1:0] rd_data
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/loop_fetch_bypass.sv
`timescale 1ns/1ps
module loop_fetch_bypass
  import lfb_pkg::*;
#(
  parameter int AW     = 16,
  parameter int IW     = 8,
  parameter int NLOOP  = 2,
  parameter int LDEPTH = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  output logic [$clog2(2*NLOOP+1)-1:0]      cfg_rd_addr,
  input  logic [AW-1:0]                     cfg_rd_data,
  input  logic                              tbl_wr_en,
  input  logic [$clog2(NLOOP*LDEPTH)-1:0]   tbl_wr_addr,
  input  logic [IW+1:0]                     tbl_wr_data,
  input  logic                              fetch_req,
  input  logic [AW-1:0]                     fetch_addr,
  input  logic                              jump_taken,
  input  logic [IW-1:0]                     rom_data,
  output logic                              rom_en,
  output logic [IW-1:0]                     instr_out,
  output logic                              from_table,
  output logic                              bypass_on
);
  localparam int TW    = $clog2(NLOOP*LDEPTH);
  localparam int CAW   = $clog2(2*NLOOP+1);
  localparam int DEPTH = NLOOP*LDEPTH;
  localparam logic [AW-1:0] SPAN_LIM = AW'(LDEPTH);

  // reset: asynchronous assert, synchronous release
  logic rst_q1, rst_q2, rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q2, rst_q1} <= 2'b00;
    else        {rst_q2, rst_q1} <= {rst_q1, 1'b1};
  end
  assign rst_int = rst_q2;

  logic [NLOOP-1:0][AW-1:0] loop_start, loop_end;
  logic [NLOOP-1:0]         loop_valid;
  logic                     hit;
  logic [AW-1:0]            hit_start;
  logic [TW-1:0]            hit_base;
  logic [IW+1:0]            rd_word;
  logic [TW-1:0]            rd_idx;

  lfb_cfg_loader #(.AW(AW), .NLOOP(NLOOP), .LDEPTH(LDEPTH), .CAW(CAW)) u_loader (
    .clk(clk), .rst_n(rst_int),
    .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
    .loop_start(loop_start), .loop_end(loop_end), .loop_valid(loop_valid),
    .bypass_on(bypass_on)
  );

  lfb_range_match #(.AW(AW), .NLOOP(NLOOP), .LDEPTH(LDEPTH), .TW(TW)) u_match (
    .fetch_addr(fetch_addr), .loop_start(loop_start), .loop_end(loop_end),
    .loop_valid(loop_valid), .hit(hit), .hit_start(hit_start), .hit_base(hit_base)
  );

  lfb_table #(.WW(IW+2), .DEPTH(DEPTH), .TW(TW)) u_table (
    .clk(clk), .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr), .wr_data(tbl_wr_data),
    .rd_addr(rd_idx), .rd_data(rd_word)
  );

  // loop tracking state
  logic        in_loop_q, in_loop_d;
  exit_code_e  prev_code_q, prev_code_d;
  logic [AW-1:0] act_start_q, act_start_d;
  logic [TW-1:0] act_base_q, act_base_d;

  exit_code_e  tbl_code;
  logic        leave, stay, enter, use_tbl;
  logic [AW-1:0] in_off, en_off;

  always_comb begin
    tbl_code = exit_code_e'(rd_word[IW+1:IW]);
    leave = in_loop_q &&
            (((prev_code_q == EXIT_ON_TAKEN) &&  jump_taken) ||
             ((prev_code_q == EXIT_ON_FALL)  && !jump_taken) ||
              (prev_code_q == EXIT_ALWAYS));
    stay    = in_loop_q && !leave;
    enter   = !in_loop_q && bypass_on && hit;
    use_tbl = fetch_req && (stay || enter);
    in_off  = fetch_addr - act_start_q;
    en_off  = fetch_addr - hit_start;
    rd_idx  = stay ? (TW'(in_off) + act_base_q) : (TW'(en_off) + hit_base);
  end

  always_comb begin
    in_loop_d   = in_loop_q;
    prev_code_d = prev_code_q;
    act_start_d = act_start_q;
    act_base_d  = act_base_q;
    if (fetch_req) begin
      in_loop_d   = use_tbl;
      prev_code_d = use_tbl ? tbl_code : EXIT_NONE;
      if (enter) begin
        act_start_d = hit_start;
        act_base_d  = hit_base;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      in_loop_q   <= 1'b0;
      prev_code_q <= EXIT_NONE;
      act_start_q <= '0;
      act_base_q  <= '0;
    end else if (fetch_req) begin
      in_loop_q   <= in_loop_d;
      prev_code_q <= prev_code_d;
      act_start_q <= act_start_d;
      act_base_q  <= act_base_d;
    end
  end

  assign from_table = use_tbl;
  assign rom_en     = fetch_req && !use_tbl;
  assign instr_out  = use_tbl ? rd_word[IW-1:0] : rom_data;

  // R2: nothing comes from the table before the loader enables the bypass
  assert_no_table_while_off_R2: assert property (@(posedge clk) disable iff (!rst_int)
    !bypass_on |-> !from_table);
  // R4: an entry fetch always lands inside its slot
  assert_entry_in_slot_R4: assert property (@(posedge clk) disable iff (!rst_int)
    (fetch_req && !in_loop_q && from_table) |-> (en_off < SPAN_LIM));
  // R5: a 00 instruction keeps the stream in the table
  assert_stay_on_none_R5: assert property (@(posedge clk) disable iff (!rst_int)
    (fetch_req && $past(fetch_req) && $past(from_table) &&
     ($past(rd_word[IW+1:IW]) == 2'b00)) |-> from_table);
  // R6: 01 with a taken jump hands back to ROM
  assert_leave_taken_R6: assert property (@(posedge clk) disable iff (!rst_int)
    (fetch_req && jump_taken && $past(fetch_req) && $past(from_table) &&
     ($past(rd_word[IW+1:IW]) == 2'b01)) |-> (rom_en && !from_table));
  // R7: 10 with a jump not taken hands back to ROM
  assert_leave_fall_R7: assert property (@(posedge clk) disable iff (!rst_int)
    (fetch_req && !jump_taken && $past(fetch_req) && $past(from_table) &&
     ($past(rd_word[IW+1:IW]) == 2'b10)) |-> (rom_en && !from_table));
  // R8: 11 always hands back to ROM
  assert_leave_always_R8: assert property (@(posedge clk) disable iff (!rst_int)
    (fetch_req && $past(fetch_req) && $past(from_table) &&
     ($past(rd_word[IW+1:IW]) == 2'b11)) |-> !from_table);
endmodule

// File: tb/loop_fetch_bypass_test.sv
`timescale 1ns/1ps
module loop_fetch_bypass_test;
  localparam int AW = 16, IW = 8, NLOOP = 2, LDEPTH = 32;
  localparam int DEPTH = NLOOP*LDEPTH;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0]    cfg_rd_addr;
  logic [AW-1:0] cfg_rd_data;
  logic          tbl_wr_en;
  logic [5:0]    tbl_wr_addr;
  logic [IW+1:0] tbl_wr_data;
  logic          fetch_req, jump_taken;
  logic [AW-1:0] fetch_addr;
  logic [IW-1:0] rom_data, instr_out;
  logic          rom_en, from_table, bypass_on;
  logic [AW-1:0] cfg_mem [5];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  loop_fetch_bypass #(.AW(AW), .IW(IW), .NLOOP(NLOOP), .LDEPTH(LDEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .jump_taken(jump_taken),
    .rom_data(rom_data), .rom_en(rom_en), .instr_out(instr_out),
    .from_table(from_table), .bypass_on(bypass_on)
  );

  // behavioural ROM and configuration memory
  assign rom_data    = fetch_addr[7:0] ^ fetch_addr[15:8] ^ 8'hA5;
  assign cfg_rd_data = (cfg_rd_addr < 3'd5) ? cfg_mem[cfg_rd_addr] : '0;

  function automatic logic [IW-1:0] tbl_instr(int idx);
    return 8'(idx) ^ 8'h3C;
  endfunction

  function automatic logic [1:0] tbl_code(int idx);
    case (idx)
      3, 33:   return 2'b01;
      7:       return 2'b10;
      35, 63:  return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one fetch at the falling edge, check the combinational result
  task automatic do_fetch(bit req, bit taken, logic [AW-1:0] addr,
                          bit exp_tbl, int idx, string tag);
    logic [IW-1:0] exp_i;
    @(negedge clk);
    fetch_req  = req;
    jump_taken = taken;
    fetch_addr = addr;
    #1;
    if (req) begin
      exp_i = exp_tbl ? tbl_instr(idx) : (addr[7:0] ^ addr[15:8] ^ 8'hA5);
      check(from_table == exp_tbl && rom_en == !exp_tbl, tag,
            {30'd0, from_table, rom_en}, {30'd0, exp_tbl, !exp_tbl});
      check(instr_out == exp_i, tag, 32'(instr_out), 32'(exp_i));
    end else begin
      check(!rom_en && !from_table, tag, {30'd0, from_table, rom_en}, 32'd0);
    end
  endtask

  task automatic apply_config(logic flag, logic [15:0] s0, logic [15:0] e0,
                              logic [15:0] s1, logic [15:0] e1);
    cfg_mem[0] = {15'd0, flag};
    cfg_mem[1] = s0; cfg_mem[2] = e0;
    cfg_mem[3] = s1; cfg_mem[4] = e1;
    fetch_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(posedge clk);
  endtask

  // vector: [28:25] req tag, [24] fetch_req, [23] jump_taken,
  //         [22:7] address, [6] expect table, [5:0] table index
  localparam logic [28:0] VEC [37] = '{
    {4'd3, 1'b1,1'b0,16'h0050,1'b0,6'd0},   // R3 outside any loop
    {4'd4, 1'b1,1'b0,16'h0100,1'b1,6'd0},   // R4 enter slot 0
    {4'd5, 1'b1,1'b0,16'h0101,1'b1,6'd1},
    {4'd5, 1'b1,1'b0,16'h0102,1'b1,6'd2},
    {4'd5, 1'b1,1'b0,16'h0103,1'b1,6'd3},
    {4'd6, 1'b1,1'b0,16'h0104,1'b1,6'd4},   // R6 01, not taken: stay
    {4'd10,1'b0,1'b0,16'h0105,1'b0,6'd0},   // R10 stall
    {4'd10,1'b1,1'b0,16'h0105,1'b1,6'd5},   // R10 resume in table
    {4'd5, 1'b1,1'b0,16'h0106,1'b1,6'd6},
    {4'd5, 1'b1,1'b0,16'h0107,1'b1,6'd7},
    {4'd7, 1'b1,1'b1,16'h0100,1'b1,6'd0},   // R7 10, taken: loop back
    {4'd5, 1'b1,1'b0,16'h0101,1'b1,6'd1},
    {4'd5, 1'b1,1'b0,16'h0102,1'b1,6'd2},
    {4'd5, 1'b1,1'b0,16'h0103,1'b1,6'd3},
    {4'd6, 1'b1,1'b1,16'h0110,1'b0,6'd0},   // R6 01, taken: leave
    {4'd3, 1'b1,1'b0,16'h0111,1'b0,6'd0},
    {4'd4, 1'b1,1'b0,16'h0100,1'b1,6'd0},
    {4'd5, 1'b1,1'b0,16'h0101,1'b1,6'd1},
    {4'd5, 1'b1,1'b0,16'h0102,1'b1,6'd2},
    {4'd5, 1'b1,1'b0,16'h0103,1'b1,6'd3},
    {4'd6, 1'b1,1'b0,16'h0104,1'b1,6'd4},
    {4'd5, 1'b1,1'b0,16'h0105,1'b1,6'd5},
    {4'd5, 1'b1,1'b0,16'h0106,1'b1,6'd6},
    {4'd5, 1'b1,1'b0,16'h0107,1'b1,6'd7},
    {4'd7, 1'b1,1'b0,16'h0108,1'b0,6'd0},   // R7 10, not taken: leave
    {4'd4, 1'b1,1'b0,16'h0200,1'b1,6'd32},  // R4 slot 1 base
    {4'd5, 1'b1,1'b0,16'h0201,1'b1,6'd33},
    {4'd6, 1'b1,1'b0,16'h0202,1'b1,6'd34},  // R6 01 not taken
    {4'd5, 1'b1,1'b0,16'h0203,1'b1,6'd35},
    {4'd8, 1'b1,1'b0,16'h0204,1'b0,6'd0},   // R8 11 not taken leaves
    {4'd4, 1'b1,1'b0,16'h0203,1'b1,6'd35},  // R4 mid-range entry
    {4'd8, 1'b1,1'b1,16'h0090,1'b0,6'd0},   // R8 11 taken leaves
    {4'd4, 1'b1,1'b0,16'h0201,1'b1,6'd33},
    {4'd6, 1'b1,1'b1,16'h0300,1'b0,6'd0},   // R6 taken leave
    {4'd4, 1'b1,1'b0,16'h0106,1'b1,6'd6},
    {4'd5, 1'b1,1'b0,16'h0107,1'b1,6'd7},
    {4'd7, 1'b1,1'b0,16'h0108,1'b0,6'd0}
  };

  initial begin
    rst_n = 1'b0;
    fetch_req = 1'b0; jump_taken = 1'b0; fetch_addr = '0;
    tbl_wr_en = 1'b0; tbl_wr_addr = '0; tbl_wr_data = '0;
    cfg_mem[0] = 16'h0001;
    cfg_mem[1] = 16'h0100; cfg_mem[2] = 16'h0107;
    cfg_mem[3] = 16'h0200; cfg_mem[4] = 16'h0203;

    // fill the loop table while reset is held
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      tbl_wr_en   = 1'b1;
      tbl_wr_addr = 6'(i);
      tbl_wr_data = {tbl_code(i), tbl_instr(i)};
    end
    @(negedge clk);
    tbl_wr_en = 1'b0;
    #1;
    // R1 reset state
    check(!bypass_on && !from_table && !rom_en && cfg_rd_addr == 3'd0,
          "R1 reset state", {28'd0, cfg_rd_addr, bypass_on}, 32'd0);

    // R1 release and count edges to the enable
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(!bypass_on, "R1 bypass low after 6 edges", 32'(bypass_on), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check(bypass_on, "R1 bypass high after 7 edges", 32'(bypass_on), 32'd1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bypass_on, "R1 bypass sticky", 32'(bypass_on), 32'd1);

    for (int v = 0; v < 37; v++) begin
      do_fetch(VEC[v][24], VEC[v][23], VEC[v][22:7], VEC[v][6], int'(VEC[v][5:0]),
               $sformatf("R%0d vector %0d", VEC[v][28:25], v));
    end

    // R9 and R11: slot 1 of exactly LDEPTH words overlapping slot 0
    apply_config(1'b1, 16'h0300, 16'h0303, 16'h0302, 16'h0321);
    do_fetch(1'b1, 1'b0, 16'h0321, 1'b1, 63, "R9 full-span slot accepted");
    do_fetch(1'b1, 1'b0, 16'h0302, 1'b0, 0,  "R8 leave after 11");
    do_fetch(1'b1, 1'b0, 16'h0302, 1'b1, 2,  "R11 lower slot wins");

    // R9: oversize span and reversed bounds never match
    apply_config(1'b1, 16'h0400, 16'h0420, 16'h0500, 16'h04F0);
    check(bypass_on, "R9 bypass on", 32'(bypass_on), 32'd1);
    do_fetch(1'b1, 1'b0, 16'h0405, 1'b0, 0, "R9 oversize slot ignored");
    do_fetch(1'b1, 1'b0, 16'h0420, 1'b0, 0, "R9 oversize slot end ignored");
    do_fetch(1'b1, 1'b0, 16'h0500, 1'b0, 0, "R9 reversed slot ignored");

    // R2: flag clear keeps everything on ROM
    apply_config(1'b0, 16'h0100, 16'h0107, 16'h0200, 16'h0203);
    check(!bypass_on, "R2 bypass stays off", 32'(bypass_on), 32'd0);
    do_fetch(1'b1, 1'b0, 16'h0100, 1'b0, 0, "R2 loop address from ROM");
    do_fetch(1'b1, 1'b0, 16'h0201, 1'b0, 0, "R2 second loop from ROM");

    @(negedge clk);
    fetch_req = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule